// File: doc/BRIEF.md
# Packet Number Queue Manager

This block keeps the three ordered lists of 5-bit packet numbers that a shared-buffer Ethernet controller passes between its CPU, its DMA engine and its buffer allocator.

The first list holds transmit work. The CPU places numbers on it, and the DMA side takes them off when the MAC can start another frame. The second list holds finished transmissions that the CPU has not yet acknowledged. The third list holds numbers of complete, valid received frames, in arrival order, until the CPU removes them.

A mode input decides what happens to a successfully sent number. It is either handed straight back to the allocator as a release, or it is kept in the completion list like any other finished transmission. Removing a received number can optionally release its buffer in the same cycle.

Each CPU-visible head port carries an explicit empty bit next to the number. Simultaneous writes and removals on one list both take effect. Illegal accesses are dropped and recorded in a sticky error flag.

Top module: `pkt_queue_mgr`

## Requirements
- R1: After reset all three lists are empty, `err` is 0, `tx_empty` is 1, `tx_int` is 0 and each 6-bit port reads 6'h20. Port encoding: bit 5 is the empty bit, bits 4:0 are the head number, and they are forced to 0 when the list is empty.
- R2: A `cpu_enq` pulse appends `cpu_pnr` to the transmit list. Numbers leave in the order they were appended, whatever their values.
- R3: `dma_tx_pop` removes the transmit head. `tx_port` shows the next head one cycle after the clock edge. `tx_empty` is 1 exactly when the transmit list holds nothing.
- R4: When `tx_done`, `tx_ok` and `auto_rel` are all 1, `tx_rel_req` is 1 in that same cycle with `tx_rel_num` equal to `tx_done_num`, and the completion list is left unchanged.
- R5: Any other `tx_done` (either `tx_ok` is 0 or `auto_rel` is 0) appends `tx_done_num` to the completion list. `txc_port` shows its head, `tx_int` is 1 while the list is non-empty, and `cpu_txack` removes the head.
- R6: `dma_rx_push` appends `dma_rx_num` to the receive list. `rx_port` shows the oldest entry.
- R7: `cpu_rx_rm` removes the receive head without a release. `cpu_rx_rm_rel` removes it and, in the same cycle, raises `rx_rel_req` with `rx_rel_num` equal to that head.
- R8: Each list holds up to DEPTH (18) entries. A write to a full list with no removal that cycle is ignored and sets `err`.
- R9: A removal from an empty list is ignored, leaves the list empty, produces no release, and sets `err`. `err` stays 1 until reset.
- R10: A write and a removal on the same list in one cycle both take effect, including when the list is full. On an empty list the write lands and the removal is flagged as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_enq | input | 1 | Append `cpu_pnr` to the transmit list |
| cpu_pnr | input | 5 | Packet number written by the CPU |
| dma_tx_pop | input | 1 | DMA takes the transmit head |
| tx_done | input | 1 | A transmission has finished |
| tx_ok | input | 1 | The finished transmission succeeded |
| auto_rel | input | 1 | Release successful numbers instead of queueing them |
| tx_done_num | input | 5 | Number of the finished transmission |
| cpu_txack | input | 1 | Acknowledge and remove the completion head |
| dma_rx_push | input | 1 | Append a received packet number |
| dma_rx_num | input | 5 | Received packet number |
| cpu_rx_rm | input | 1 | Remove the receive head |
| cpu_rx_rm_rel | input | 1 | Remove the receive head and release its buffer |
| tx_port | output | 6 | Transmit head {empty, number} |
| txc_port | output | 6 | Completion head {empty, number} |
| rx_port | output | 6 | Receive head {empty, number} |
| tx_empty | output | 1 | Transmit list holds nothing |
| tx_int | output | 1 | Completion list is non-empty |
| tx_rel_req | output | 1 | Release request from automatic transmit release |
| tx_rel_num | output | 5 | Number released by `tx_rel_req` |
| rx_rel_req | output | 1 | Release request from remove-and-release |
| rx_rel_num | output | 5 | Number released by `rx_rel_req` |
| err | output | 1 | Sticky illegal-access flag |

## Verification
The assertions check, on every cycle, the per-cycle rules of the lists:
- the occupancy never passes DEPTH;
- a full list that sees a write and a removal together stays full;
- an append always leaves the transmit list non-empty;
- a removal from an empty list raises `err`, and `err` never falls before reset;
- an automatic release never disturbs the completion head.

Only the bench scenarios can show that numbers come out in the order they went in, that a dropped write never reappears, and that release numbers match the head that was actually removed.

// File: rtl/pkt_queue_mgr.sv
module pkt_queue_mgr #(
  parameter int NW    = 5,
  parameter int DEPTH = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_enq,
  input  logic [NW-1:0] cpu_pnr,
  input  logic          dma_tx_pop,
  input  logic          tx_done,
  input  logic          tx_ok,
  input  logic          auto_rel,
  input  logic [NW-1:0] tx_done_num,
  input  logic          cpu_txack,
  input  logic          dma_rx_push,
  input  logic [NW-1:0] dma_rx_num,
  input  logic          cpu_rx_rm,
  input  logic          cpu_rx_rm_rel,
  output logic [NW:0]   tx_port,
  output logic [NW:0]   txc_port,
  output logic [NW:0]   rx_port,
  output logic          tx_empty,
  output logic          tx_int,
  output logic          tx_rel_req,
  output logic [NW-1:0] tx_rel_num,
  output logic          rx_rel_req,
  output logic [NW-1:0] rx_rel_num,
  output logic          err
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NQ = 3;

  logic [NQ-1:0]    push, pop_req, emp, bad;
  logic [NQ*NW-1:0] din, heads;

  assign tx_rel_req = tx_done & tx_ok & auto_rel;
  assign tx_rel_num = tx_done_num;

  assign push    = {dma_rx_push, tx_done & ~tx_rel_req, cpu_enq};
  assign pop_req = {cpu_rx_rm | cpu_rx_rm_rel, cpu_txack, dma_tx_pop};
  assign din     = {dma_rx_num, tx_done_num, cpu_pnr};

  for (genvar q = 0; q < NQ; q++) begin : q_g
    logic [NW-1:0] mem [DEPTH];
    logic [PW-1:0] rd, wr;
    logic [CW-1:0] cnt;
    logic full, pop_ok, push_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign emp[q]  = (cnt == '0);
    assign pop_ok  = pop_req[q] & ~emp[q];
    assign push_ok = push[q] & (~full | pop_ok);
    assign bad[q]  = (pop_req[q] & emp[q]) | (push[q] & ~push_ok);
    assign heads[q*NW +: NW] = emp[q] ? '0 : mem[rd];

    always_ff @(posedge clk) begin
      if (push_ok) mem[wr] <= din[q*NW +: NW];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd  <= '0;
        wr  <= '0;
        cnt <= '0;
      end else begin
        if (push_ok) wr <= (wr == PW'(DEPTH - 1)) ? '0 : wr + 1'b1;
        if (pop_ok)  rd <= (rd == PW'(DEPTH - 1)) ? '0 : rd + 1'b1;
        cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
    a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (push[q] && pop_req[q] && cnt == CW'(DEPTH)) |=> cnt == CW'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err | (|bad);
  end

  assign tx_port  = {emp[0], heads[0 +: NW]};
  assign txc_port = {emp[1], heads[NW +: NW]};
  assign rx_port  = {emp[2], heads[2*NW +: NW]};
  assign tx_empty = emp[0];
  assign tx_int   = ~emp[1];

  assign rx_rel_req = cpu_rx_rm_rel & ~emp[2];
  assign rx_rel_num = heads[2*NW +: NW];

  a_r2_enq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_enq && !dma_tx_pop) |=> !tx_empty);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r9_pop_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_pop && tx_empty) |=> err);
  a_r4_auto_rel_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_ok && auto_rel && !cpu_txack) |=> $stable(txc_port));
endmodule

// File: tb/pkt_queue_mgr_tb.sv
`timescale 1ns/1ps
module pkt_queue_mgr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_enq = 0, dma_tx_pop = 0, tx_done = 0, tx_ok = 0, auto_rel = 0;
  logic cpu_txack = 0, dma_rx_push = 0, cpu_rx_rm = 0, cpu_rx_rm_rel = 0;
  logic [4:0] cpu_pnr = 0, tx_done_num = 0, dma_rx_num = 0;
  logic [5:0] tx_port, txc_port, rx_port;
  logic tx_empty, tx_int, tx_rel_req, rx_rel_req, err;
  logic [4:0] tx_rel_num, rx_rel_num;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_queue_mgr u_dut (.*);

  // {enq, pnr, txpop, rxpush, rxnum, rxrm, rxrel, exp_tx, exp_rx}
  localparam logic [26:0] VEC [9] = '{
    {1'b1, 5'd3,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 6'h03, 6'h20},
    {1'b1, 5'd17, 1'b0, 1'b1, 5'd9,  1'b0, 1'b0, 6'h03, 6'h09},
    {1'b1, 5'd0,  1'b0, 1'b1, 5'd30, 1'b0, 1'b0, 6'h03, 6'h09},
    {1'b0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 6'h11, 6'h09},
    {1'b1, 5'd31, 1'b1, 1'b0, 5'd0,  1'b1, 1'b0, 6'h00, 6'h1E},
    {1'b0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b0, 1'b1, 6'h1F, 6'h20},
    {1'b0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 6'h20, 6'h20},
    {1'b0, 5'd0,  1'b0, 1'b1, 5'd5,  1'b1, 1'b0, 6'h20, 6'h05},
    {1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 6'h20, 6'h20}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    cpu_enq = 0; dma_tx_pop = 0; tx_done = 0; tx_ok = 0; cpu_txack = 0;
    dma_rx_push = 0; cpu_rx_rm = 0; cpu_rx_rm_rel = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; clr();
  endtask

  task automatic do_reset();
    clr(); auto_rel = 0; rst_n = 0;
    step(); step(); rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 tx_port", tx_port, 6'h20);
    chk("R1 txc_port", txc_port, 6'h20);
    chk("R1 rx_port", rx_port, 6'h20);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_int", tx_int, 0);
    chk("R1 err", err, 0);

    // R2 R3 R6 R7 R10 vector walk
    foreach (VEC[i]) begin
      {cpu_enq, cpu_pnr, dma_tx_pop, dma_rx_push, dma_rx_num, cpu_rx_rm, cpu_rx_rm_rel} = VEC[i][26:12];
      step();
      chk("R2/R3 tx_port vec", tx_port, VEC[i][11:6]);
      chk("R6/R7/R10 rx_port vec", rx_port, VEC[i][5:0]);
    end
    chk("R10 empty pop flagged", err, 1);

    // R9 err sticky, pop on empty ignored
    dma_tx_pop = 1; step();
    chk("R9 tx stays empty", tx_port, 6'h20);
    cpu_enq = 1; cpu_pnr = 5'd4; step();
    chk("R9 err sticky", err, 1);

    // R4 auto release
    do_reset();
    chk("R1 err cleared", err, 0);
    auto_rel = 1; tx_done = 1; tx_ok = 1; tx_done_num = 5'd12; #1;
    chk("R4 rel req", tx_rel_req, 1);
    chk("R4 rel num", tx_rel_num, 12);
    step();
    chk("R4 not queued", txc_port, 6'h20);
    chk("R4 tx_int", tx_int, 0);

    // R5 completion queue
    tx_done = 1; tx_ok = 0; tx_done_num = 5'd7; #1;
    chk("R5 no rel on fail", tx_rel_req, 0);
    step();
    auto_rel = 0; tx_done = 1; tx_ok = 1; tx_done_num = 5'd8; step();
    chk("R5 head", txc_port, 6'h07);
    chk("R5 tx_int", tx_int, 1);
    cpu_txack = 1; step();
    chk("R5 ack", txc_port, 6'h08);
    cpu_txack = 1; step();
    chk("R5 drained", txc_port, 6'h20);
    chk("R5 tx_int low", tx_int, 0);

    // R7 release on remove
    dma_rx_push = 1; dma_rx_num = 5'd4; step();
    dma_rx_push = 1; dma_rx_num = 5'd6; step();
    cpu_rx_rm_rel = 1; #1;
    chk("R7 rel req", rx_rel_req, 1);
    chk("R7 rel num", rx_rel_num, 4);
    step();
    chk("R7 next head", rx_port, 6'h06);
    cpu_rx_rm = 1; #1;
    chk("R7 plain no rel", rx_rel_req, 0);
    step();
    chk("R7 emptied", rx_port, 6'h20);
    cpu_rx_rm_rel = 1; #1;
    chk("R9 no rel on empty", rx_rel_req, 0);
    step();

    // R8 capacity and overflow
    do_reset();
    for (int i = 0; i < 18; i++) begin cpu_enq = 1; cpu_pnr = 5'(i + 1); step(); end
    chk("R8 full no err", err, 0);
    chk("R8 head", tx_port, 6'h01);
    cpu_enq = 1; cpu_pnr = 5'd25; step();
    chk("R8 overflow err", err, 1);
    for (int i = 0; i < 18; i++) begin
      chk("R8 order", tx_port, i + 1);
      dma_tx_pop = 1; step();
    end
    chk("R8 dropped write absent", tx_port, 6'h20);

    // R10 push+pop at full
    do_reset();
    for (int i = 0; i < 18; i++) begin dma_rx_push = 1; dma_rx_num = 5'(i); step(); end
    dma_rx_push = 1; dma_rx_num = 5'd20; cpu_rx_rm = 1; step();
    chk("R10 no err at full swap", err, 0);
    for (int i = 1; i < 18; i++) begin
      chk("R10 order", rx_port, i);
      cpu_rx_rm = 1; step();
    end
    chk("R10 swapped-in tail", rx_port, 6'h14);
    cpu_rx_rm = 1; step();
    chk("R10 drained", rx_port, 6'h20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule